// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block protects a 10 Mb/s Ethernet transmitter against a transmission that never stops. It watches the transmit request from the MAC and counts how long each transmission lasts. When a single transmission runs past a configured limit, the block latches a jabber condition. While that condition holds it takes three protective actions: it gates the transmit enable off, it withdraws automatic loopback (loopback is only offered in twisted-pair mode), and it raises a collision indication towards the MAC.

The jabber condition is cleared only after the transmit request has stayed low without a break for a long release interval. Any activity on the request during that interval starts the interval over. Both intervals are parameters counted in clock cycles. The defaults correspond to 32 ms and 256 ms at a 50 MHz clock, and simulation can shrink them to a few cycles. All pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `jab_watchdog`

## Requirements
- R1: While reset is held and directly after it, `coll_o` is 0, `tx_en_o` equals `tx_req` and `lpbk_en_o` equals `tp_mode`. This is the normal (non-jabber) state.
- R2: In the normal state `tx_en_o` follows `tx_req` in the same cycle, with no added delay.
- R3: A transmission with `tx_req` high on at most MAX_TX_CYC consecutive rising clock edges never enters the jabber state.
- R4: If `tx_req` is sampled high on MAX_TX_CYC+1 consecutive rising edges in the normal state, the jabber state begins at that last edge. From then on `coll_o` is 1.
- R5: In the jabber state `lpbk_en_o` is 0. In the normal state it equals `tp_mode` (1 = twisted-pair mode).
- R6: The jabber state ends at the rising edge where `tx_req` has been sampled low on UNJAB_CYC consecutive edges counted from jabber entry or from the last high sample, whichever is later. After that edge `coll_o` is 0.
- R7: A high sample of `tx_req` during the jabber state restarts the release count from zero. A request held high keeps the block in jabber indefinitely.
- R8: The length count restarts with each new transmission. One low sample between two bursts clears it, so two bursts of MAX_TX_CYC cycles separated by a gap do not trip.
- R9: In the jabber state `tx_en_o` is 0 whatever the value of `tx_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Transmit request from the MAC, high while a frame is sent |
| tp_mode | input | 1 | 1 = twisted-pair medium, 0 = coax/attachment-unit medium |
| tx_en_o | output | 1 | Gated transmit enable to the line driver |
| lpbk_en_o | output | 1 | Automatic loopback enable |
| coll_o | output | 1 | Collision indication to the MAC, high while jabbering |

## Verification
The length timer is driven with a burst of exactly the permitted length, a burst one cycle longer, and two maximal bursts split by a single idle cycle. Together these separate an off-by-one in the trip threshold from a counter that fails to clear between frames. The release timer is driven with an idle run broken by one request pulse, an unbroken idle run of exactly the release length, and a request held high through a long stretch of jabber. These show that release needs an uninterrupted idle interval and that it fires on the exact edge. Medium mode is toggled both inside and outside jabber to confirm that loopback suppression depends on the jabber state.

// File: rtl/jab_pkg.sv
package jab_pkg;

  typedef enum logic {
    JS_NORMAL = 1'b0,
    JS_JABBER = 1'b1
  } jab_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/jab_len_timer.sv
module jab_len_timer
  import jab_pkg::*;
#(
  parameter int unsigned MAX_TX_CYC = 1_600_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  jab_state_e state,
  output logic       trip
);
  localparam int unsigned LW = cnt_width(MAX_TX_CYC);
  localparam logic [LW-1:0] LIMIT = LW'(MAX_TX_CYC);

  logic [LW-1:0] run_len;
  logic          active;

  assign active = tx_req && (state == JS_NORMAL);
  assign trip   = active && (run_len == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (!active || trip) begin
      run_len <= '0;
    end else begin
      run_len <= run_len + 1'b1;
    end
  end

endmodule

// File: rtl/jab_idle_timer.sv
module jab_idle_timer
  import jab_pkg::*;
#(
  parameter int unsigned UNJAB_CYC = 12_800_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  jab_state_e state,
  output logic       release_o
);
  localparam int unsigned IW = cnt_width(UNJAB_CYC);
  localparam logic [IW-1:0] LAST = IW'(UNJAB_CYC - 1);

  logic [IW-1:0] quiet_len;
  logic          counting;

  assign counting  = (state == JS_JABBER) && !tx_req;
  assign release_o = counting && (quiet_len == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_len <= '0;
    end else if (!counting || release_o) begin
      quiet_len <= '0;
    end else begin
      quiet_len <= quiet_len + 1'b1;
    end
  end

endmodule

// File: rtl/jab_out_gate.sv
module jab_out_gate
  import jab_pkg::*;
(
  input  jab_state_e state,
  input  logic       tx_req,
  input  logic       tp_mode,
  output logic       tx_en_o,
  output logic       lpbk_en_o,
  output logic       coll_o
);
  logic jabbing;

  always_comb begin
    jabbing   = (state == JS_JABBER);
    tx_en_o   = tx_req && !jabbing;
    lpbk_en_o = tp_mode && !jabbing;
    coll_o    = jabbing;
  end

endmodule

// File: rtl/jab_watchdog.sv
module jab_watchdog
  import jab_pkg::*;
#(
  parameter int unsigned MAX_TX_CYC = 1_600_000,
  parameter int unsigned UNJAB_CYC  = 12_800_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic tp_mode,
  output logic tx_en_o,
  output logic lpbk_en_o,
  output logic coll_o
);
  jab_state_e state_q;
  jab_state_e state_d;
  logic       trip;
  logic       rel;

  jab_len_timer #(.MAX_TX_CYC(MAX_TX_CYC)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_req(tx_req),
    .state (state_q),
    .trip  (trip)
  );

  jab_idle_timer #(.UNJAB_CYC(UNJAB_CYC)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_req   (tx_req),
    .state    (state_q),
    .release_o(rel)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      JS_NORMAL: if (trip) state_d = JS_JABBER;
      JS_JABBER: if (rel)  state_d = JS_NORMAL;
      default:             state_d = JS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= JS_NORMAL;
    else        state_q <= state_d;
  end

  jab_out_gate u_gate (
    .state    (state_q),
    .tx_req   (tx_req),
    .tp_mode  (tp_mode),
    .tx_en_o  (tx_en_o),
    .lpbk_en_o(lpbk_en_o),
    .coll_o   (coll_o)
  );

endmodule

// File: rtl/jab_watchdog_chk.sv
module jab_watchdog_chk #(
  parameter int unsigned MAX_TX_CYC = 1_600_000,
  parameter int unsigned UNJAB_CYC  = 12_800_000
) (
  input logic clk,
  input logic rst_n,
  input logic tx_req,
  input logic tp_mode,
  input logic tx_en_o,
  input logic lpbk_en_o,
  input logic coll_o
);
  localparam int unsigned RW = $clog2(MAX_TX_CYC + 3);
  localparam int unsigned QW = $clog2(UNJAB_CYC + 2);

  logic [RW-1:0] busy_run;
  logic [QW-1:0] quiet_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run  <= '0;
      quiet_run <= '0;
    end else begin
      if (coll_o || !tx_req)                     busy_run <= '0;
      else if (busy_run <= RW'(MAX_TX_CYC))      busy_run <= busy_run + 1'b1;
      if (!coll_o || tx_req)                     quiet_run <= '0;
      else if (quiet_run <= QW'(UNJAB_CYC))      quiet_run <= quiet_run + 1'b1;
    end
  end

  AST_JAB_GATES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    coll_o |-> !tx_en_o);                                              // R9
  AST_JAB_NO_LPBK: assert property (@(posedge clk) disable iff (!rst_n)
    coll_o |-> !lpbk_en_o);                                            // R5
  AST_TRIP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_o) |-> ($past(tx_req) && $past(busy_run) == RW'(MAX_TX_CYC))); // R4
  AST_NO_LONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !coll_o |-> (busy_run <= RW'(MAX_TX_CYC)));                        // R3
  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coll_o) |-> (!$past(tx_req) && $past(quiet_run) == QW'(UNJAB_CYC - 1))); // R6
  AST_REQ_HOLDS_JAB: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_o && tx_req) |=> coll_o);                                    // R7
  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !coll_o |-> (tx_en_o == tx_req && lpbk_en_o == tp_mode));          // R2

endmodule

bind jab_watchdog jab_watchdog_chk #(
  .MAX_TX_CYC(MAX_TX_CYC),
  .UNJAB_CYC (UNJAB_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_req   (tx_req),
  .tp_mode  (tp_mode),
  .tx_en_o  (tx_en_o),
  .lpbk_en_o(lpbk_en_o),
  .coll_o   (coll_o)
);

// File: tb/sim_jab_watchdog.sv
module sim_jab_watchdog;
  localparam int unsigned MAX_T = 4;
  localparam int unsigned UNJ_T = 5;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0;
  logic tp_mode = 1'b0;
  logic tx_en_o, lpbk_en_o, coll_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  jab_watchdog #(.MAX_TX_CYC(MAX_T), .UNJAB_CYC(UNJ_T)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tp_mode(tp_mode),
    .tx_en_o(tx_en_o), .lpbk_en_o(lpbk_en_o), .coll_o(coll_o)
  );

  // {tx_req, tp_mode, exp tx_en, exp lpbk, exp coll}; one entry per cycle
  localparam logic [4:0] VEC [NV] = '{
    5'b01_010,                                          // R1 idle
    5'b11_110, 5'b11_110, 5'b11_110, 5'b11_110,         // R2 burst of MAX
    5'b01_010,                                          // R3 no trip at MAX
    5'b10_100, 5'b10_100, 5'b10_100, 5'b10_100,         // coax burst
    5'b10_100,                                          // R4 fifth high trips
    5'b11_001,                                          // R9 req masked
    5'b01_001, 5'b01_001,                               // R5 no loopback
    5'b11_001,                                          // R7 restart quiet
    5'b01_001, 5'b00_001, 5'b00_001, 5'b01_001, 5'b01_001, // R6 five idle
    5'b01_010,                                          // R6 released
    5'b11_110, 5'b11_110, 5'b01_010,                    // R8 short burst
    5'b11_110, 5'b11_110, 5'b11_110, 5'b11_110,         // R8 fresh count
    5'b00_000                                           // R8 no trip
  };
  localparam int TAG [NV] = '{1, 2,2,2,2, 3, 2,2,2,2, 4, 9, 5,5, 7,
                              6,6,6,6,6, 6, 8,8,8, 8,8,8,8, 8};

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {tx_en,lpbk,coll} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic t);
    @(negedge clk);
    tx_req  = r;
    tp_mode = t;
    #2;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 during reset
    tx_req = 1'b1; tp_mode = 1'b1;
    repeat (3) @(negedge clk);
    #2 chk("R1", {tx_en_o, lpbk_en_o, coll_o}, 3'b110);
    tx_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3]);
      chk($sformatf("R%0d step %0d", TAG[i], i), {tx_en_o, lpbk_en_o, coll_o}, VEC[i][2:0]);
    end

    // R7: request held high through jabber never releases
    for (int i = 0; i < MAX_T + 1; i++) step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk("R4 re-entry", {tx_en_o, lpbk_en_o, coll_o}, 3'b001);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
    chk("R7 held request", {tx_en_o, lpbk_en_o, coll_o}, 3'b001);

    // R6: one idle sample short of release keeps jabber, then release
    for (int i = 0; i < UNJ_T; i++) step(1'b0, 1'b1);
    chk("R6 one short", {tx_en_o, lpbk_en_o, coll_o}, 3'b001);
    step(1'b1, 1'b1);
    chk("R2 after release", {tx_en_o, lpbk_en_o, coll_o}, 3'b110);

    // R1: reset in the middle of jabber returns to normal
    for (int i = 0; i < MAX_T + 1; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R9 coax jabber", {tx_en_o, lpbk_en_o, coll_o}, 3'b001);
    rst_n = 1'b0;
    #1 chk("R1 reset in jabber", {tx_en_o, lpbk_en_o, coll_o}, 3'b100);
    step(1'b1, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < MAX_T; i++) step(1'b1, 1'b1);
    chk("R3 count cleared by reset", {tx_en_o, lpbk_en_o, coll_o}, 3'b110);
    step(1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule